// File: doc/BRIEF.md
# Fetch/Execute Bus Cycle Sequencer

This block is the processor-side master of a simple shared bus. Every instruction starts with a fetch cycle. The fetch reads one word from memory at the address held in an internal instruction pointer and captures it as the instruction. The sequencer then waits for the decode logic to describe the execute phase. The execute phase is one of five kinds:

- a memory read
- a memory write
- an I/O read
- an I/O write
- no bus access at all

When the kind needs no bus access, the sequencer skips the bus cycle and goes straight back to fetching. The decode logic may also redirect the instruction pointer at this point.

The bus carries a 32-bit address and 32-bit write and read data. Three strobes describe each cycle:

- **memory/I-O select**: 1 for memory, 0 for I/O.
- **direction**: 1 when the processor drives data, 0 when the target drives data.
- **phase tag**: 0 for a fetch, 1 for an execute-phase data cycle.

Every cycle holds its strobes, address and write data until the target raises ready.

The state machine has three states:

- `SQ_FETCH`: the instruction fetch bus cycle.
- `SQ_AWAIT`: the bus is idle while the sequencer waits for a decode request.
- `SQ_EXEC`: the execute-phase bus cycle.

It has five transitions:

- **fetch-done**: `SQ_FETCH` to `SQ_AWAIT` when ready is high.
- **take-bus**: `SQ_AWAIT` to `SQ_EXEC` when a request with a bus kind is accepted.
- **take-skip**: `SQ_AWAIT` to `SQ_FETCH` when a request with a non-bus kind is accepted.
- **exec-done**: `SQ_EXEC` to `SQ_FETCH` when ready is high.
- **hold**: stay in the current state in every other case.

Top module: `bus_seq_top`

## Requirements
- R1: During and right after reset (active-low, asynchronous), the sequencer is in a fetch cycle at address 0, with both capture-valid pulses low.
- R2: A fetch cycle drives `bus_cyc`=1, `bus_mio`=1, `bus_wr`=0, `bus_dc`=0 and puts the instruction pointer on `bus_addr`. On the cycle where `bus_rdy` is high, `bus_din` is captured into `instr_out`, and `instr_vld` is high for exactly the following cycle.
- R3: The instruction pointer advances by 4 after every completed fetch.
- R4: When a request is accepted with `req_jump`=1, the instruction pointer loads `req_target`, and the next fetch uses that address.
- R5: An execute cycle drives `bus_dc`=1 and `bus_addr`=`req_addr` as it was latched at acceptance. The `req_kind` codes and their strobes (`bus_mio`,`bus_wr`) are: 1 memory read (1,0), 2 memory write (1,1), 3 I/O read (0,0), 4 I/O write (0,1).
- R6: A request accepted with `req_kind` 0 (no transfer), or with a reserved code 5 to 7, starts no execute cycle. The next cycle is a fetch.
- R7: While `bus_rdy` is low, an active cycle keeps `bus_cyc`, the strobes, `bus_addr`, `bus_dout` and `bus_oe` unchanged.
- R8: An execute read (kind 1 or 3) captures `bus_din` into `rdat_out` on its ready cycle, and `rdat_vld` is high for exactly the following cycle. Writes leave `rdat_out` unchanged.
- R9: `bus_oe` is high only during execute write cycles, and `bus_dout` equals the latched `req_wdata` there and is 0 elsewhere. While no cycle is active, `bus_cyc`, the three strobes and `bus_addr` are all 0.
- R10: `req_ready` is high exactly while waiting for a request. A `req_valid` seen while `req_ready` is low has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_ready | output | 1 | Sequencer is waiting for an execute request |
| req_valid | input | 1 | Execute request present |
| req_kind | input | 3 | Execute kind code (0 none, 1 mem rd, 2 mem wr, 3 io rd, 4 io wr) |
| req_addr | input | 32 | Execute-phase address |
| req_wdata | input | 32 | Execute-phase write data |
| req_jump | input | 1 | Load instruction pointer with req_target |
| req_target | input | 32 | New instruction pointer value |
| bus_cyc | output | 1 | A bus cycle is active |
| bus_mio | output | 1 | 1 memory, 0 I/O |
| bus_wr | output | 1 | 1 processor-to-target, 0 target-to-processor |
| bus_dc | output | 1 | 0 fetch, 1 execute data cycle |
| bus_addr | output | 32 | Address bus |
| bus_dout | output | 32 | Write data toward the target |
| bus_oe | output | 1 | Enable for the write-data drivers |
| bus_din | input | 32 | Read data from the target |
| bus_rdy | input | 1 | Target completes the current cycle |
| instr_out | output | 32 | Last fetched instruction word |
| instr_vld | output | 1 | One-cycle pulse after an instruction capture |
| rdat_out | output | 32 | Last execute-phase read word |
| rdat_vld | output | 1 | One-cycle pulse after a read capture |

## Verification
Requests cycle through all eight kind codes. This separates the four strobe encodings from one another, and it separates the no-transfer and reserved codes, which must skip straight to fetch, from the bus kinds. Target ready is sometimes immediate and sometimes delayed by several cycles, which tells a design that holds its cycle apart from one that moves early or captures stale data. Jump requests, spread among plain requests, distinguish a loaded pointer from the plain +4 advance. Spurious request strobes while the bus is busy show whether requests are accepted only while waiting.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;

    localparam int KIND_W = 3;

    typedef enum logic [KIND_W-1:0] {
        XK_NONE   = 3'd0,
        XK_MEM_RD = 3'd1,
        XK_MEM_WR = 3'd2,
        XK_IO_RD  = 3'd3,
        XK_IO_WR  = 3'd4
    } xfer_kind_e;

    typedef enum logic [1:0] {
        SQ_FETCH = 2'd0,
        SQ_AWAIT = 2'd1,
        SQ_EXEC  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic mio;
        logic wr;
        logic dc;
    } strobe_t;

    // True when the kind code moves data on the bus
    function automatic logic kind_uses_bus(logic [KIND_W-1:0] k);
        return (k == XK_MEM_RD) || (k == XK_MEM_WR) ||
               (k == XK_IO_RD)  || (k == XK_IO_WR);
    endfunction

    // Strobe pattern for an execute-phase kind
    function automatic strobe_t exec_strobes(logic [KIND_W-1:0] k);
        strobe_t s;
        s.dc  = 1'b1;
        s.mio = (k == XK_MEM_RD) || (k == XK_MEM_WR);
        s.wr  = (k == XK_MEM_WR) || (k == XK_IO_WR);
        return s;
    endfunction

endpackage

// File: rtl/bus_seq_ip.sv
module bus_seq_ip #(
    parameter int AW   = 32,
    parameter int STEP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    output logic [AW-1:0] ip
);

    localparam logic [AW-1:0] STEP_V = AW'(STEP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ip <= '0;
        end else if (load) begin
            ip <= load_val;
        end else if (adv) begin
            ip <= ip + STEP_V;
        end
    end

endmodule

// File: rtl/bus_seq_cap.sv
module bus_seq_cap #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic         vld
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q   <= '0;
            vld <= 1'b0;
        end else begin
            vld <= en;
            if (en) begin
                q <= d;
            end
        end
    end

endmodule

// File: rtl/bus_seq_fsm.sv
module bus_seq_fsm
    import bus_seq_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [KIND_W-1:0] req_kind,
    input  logic [AW-1:0]     req_addr,
    input  logic [DW-1:0]     req_wdata,
    input  logic              bus_rdy,
    output logic              req_ready,
    output logic              req_take,
    output logic              fetch_done,
    output logic              read_done,
    output logic              sel_fetch,
    output logic              sel_exec,
    output strobe_t           stb,
    output logic              oe,
    output logic [AW-1:0]     held_addr,
    output logic [DW-1:0]     held_wdata
);

    seq_state_e        state_q, state_d;
    logic [KIND_W-1:0] kind_q;
    strobe_t           ex_stb;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SQ_FETCH;
        end else begin
            state_q <= state_d;
        end
    end

    // Request hold registers, loaded on acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q     <= '0;
            held_addr  <= '0;
            held_wdata <= '0;
        end else if (req_take) begin
            kind_q     <= req_kind;
            held_addr  <= req_addr;
            held_wdata <= req_wdata;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_FETCH: if (bus_rdy) state_d = SQ_AWAIT;
            SQ_AWAIT: if (req_valid) state_d = kind_uses_bus(req_kind) ? SQ_EXEC : SQ_FETCH;
            SQ_EXEC:  if (bus_rdy) state_d = SQ_FETCH;
            default:  state_d = SQ_FETCH;
        endcase
    end

    assign ex_stb = exec_strobes(kind_q);

    // Output logic
    always_comb begin
        req_ready  = 1'b0;
        req_take   = 1'b0;
        fetch_done = 1'b0;
        read_done  = 1'b0;
        sel_fetch  = 1'b0;
        sel_exec   = 1'b0;
        stb        = '0;
        oe         = 1'b0;
        unique case (state_q)
            SQ_FETCH: begin
                sel_fetch  = 1'b1;
                stb.mio    = 1'b1;
                fetch_done = bus_rdy;
            end
            SQ_AWAIT: begin
                req_ready = 1'b1;
                req_take  = req_valid;
            end
            SQ_EXEC: begin
                sel_exec  = 1'b1;
                stb       = ex_stb;
                oe        = ex_stb.wr;
                read_done = bus_rdy && !ex_stb.wr;
            end
            default: begin
                stb = '0;
            end
        endcase
    end

endmodule

// File: rtl/bus_seq_top.sv
module bus_seq_top
    import bus_seq_pkg::*;
#(
    parameter int AW      = 32,
    parameter int DW      = 32,
    parameter int IP_STEP = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              req_ready,
    input  logic              req_valid,
    input  logic [KIND_W-1:0] req_kind,
    input  logic [AW-1:0]     req_addr,
    input  logic [DW-1:0]     req_wdata,
    input  logic              req_jump,
    input  logic [AW-1:0]     req_target,
    output logic              bus_cyc,
    output logic              bus_mio,
    output logic              bus_wr,
    output logic              bus_dc,
    output logic [AW-1:0]     bus_addr,
    output logic [DW-1:0]     bus_dout,
    output logic              bus_oe,
    input  logic [DW-1:0]     bus_din,
    input  logic              bus_rdy,
    output logic [DW-1:0]     instr_out,
    output logic              instr_vld,
    output logic [DW-1:0]     rdat_out,
    output logic              rdat_vld
);

    logic          req_take, fetch_done, read_done;
    logic          sel_fetch, sel_exec, oe;
    strobe_t       stb;
    logic [AW-1:0] ip_q, held_addr;
    logic [DW-1:0] held_wdata;

    bus_seq_fsm #(.AW(AW), .DW(DW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_kind   (req_kind),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .bus_rdy    (bus_rdy),
        .req_ready  (req_ready),
        .req_take   (req_take),
        .fetch_done (fetch_done),
        .read_done  (read_done),
        .sel_fetch  (sel_fetch),
        .sel_exec   (sel_exec),
        .stb        (stb),
        .oe         (oe),
        .held_addr  (held_addr),
        .held_wdata (held_wdata)
    );

    bus_seq_ip #(.AW(AW), .STEP(IP_STEP)) u_ip (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (fetch_done),
        .load     (req_take && req_jump),
        .load_val (req_target),
        .ip       (ip_q)
    );

    bus_seq_cap #(.W(DW)) u_icap (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (fetch_done),
        .d     (bus_din),
        .q     (instr_out),
        .vld   (instr_vld)
    );

    bus_seq_cap #(.W(DW)) u_rcap (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (read_done),
        .d     (bus_din),
        .q     (rdat_out),
        .vld   (rdat_vld)
    );

    assign bus_cyc  = sel_fetch | sel_exec;
    assign bus_mio  = stb.mio;
    assign bus_wr   = stb.wr;
    assign bus_dc   = stb.dc;
    assign bus_oe   = oe;
    assign bus_dout = oe ? held_wdata : '0;

    always_comb begin
        if (sel_fetch) begin
            bus_addr = ip_q;
        end else if (sel_exec) begin
            bus_addr = held_addr;
        end else begin
            bus_addr = '0;
        end
    end

endmodule

// File: rtl/bus_seq_chk.sv
module bus_seq_chk
    import bus_seq_pkg::*;
#(
    parameter int AW = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              req_valid,
    input logic [KIND_W-1:0] req_kind,
    input logic              bus_cyc,
    input logic              bus_mio,
    input logic              bus_wr,
    input logic              bus_dc,
    input logic [AW-1:0]     bus_addr,
    input logic              bus_oe,
    input logic              bus_rdy,
    input logic              instr_vld,
    input logic              rdat_vld,
    input logic [AW-1:0]     ip_q
);

    AST_FETCH_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && !bus_dc) |-> (bus_mio && !bus_wr)); // R2

    AST_INSTR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && !bus_dc && bus_rdy) |=> instr_vld); // R2

    AST_IP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && !bus_dc && bus_rdy) |=> (ip_q == $past(ip_q) + AW'(4))); // R3

    AST_EXEC_START: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid && kind_uses_bus(req_kind)) |=> (bus_cyc && bus_dc)); // R5

    AST_SKIP_TO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid && !kind_uses_bus(req_kind)) |=> (bus_cyc && !bus_dc)); // R6

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && !bus_rdy) |=> (bus_cyc && $stable(bus_addr) && $stable(bus_mio)
                                   && $stable(bus_wr) && $stable(bus_dc) && $stable(bus_oe))); // R7

    AST_READ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && bus_dc && !bus_wr && bus_rdy) |=> rdat_vld); // R8

    AST_OE_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> (bus_cyc && bus_dc && bus_wr)); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_cyc |-> (!bus_mio && !bus_wr && !bus_dc && bus_addr == '0)); // R9

    AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !bus_cyc); // R10

endmodule

bind bus_seq_top bus_seq_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .req_valid (req_valid),
    .req_kind  (req_kind),
    .bus_cyc   (bus_cyc),
    .bus_mio   (bus_mio),
    .bus_wr    (bus_wr),
    .bus_dc    (bus_dc),
    .bus_addr  (bus_addr),
    .bus_oe    (bus_oe),
    .bus_rdy   (bus_rdy),
    .instr_vld (instr_vld),
    .rdat_vld  (rdat_vld),
    .ip_q      (ip_q)
);

// File: tb/sim_bus_seq_top.sv
module sim_bus_seq_top;

    localparam int CLK_PERIOD = 10;
    localparam int N_REQ      = 300;
    localparam int WD_LIMIT   = 50000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_ready, req_valid, req_jump;
    logic [2:0]  req_kind;
    logic [31:0] req_addr, req_wdata, req_target;
    logic        bus_cyc, bus_mio, bus_wr, bus_dc, bus_oe, bus_rdy;
    logic [31:0] bus_addr, bus_dout, bus_din;
    logic [31:0] instr_out, rdat_out;
    logic        instr_vld, rdat_vld;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_seq_top u0 (
        .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .req_valid(req_valid),
        .req_kind(req_kind), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_jump(req_jump), .req_target(req_target), .bus_cyc(bus_cyc),
        .bus_mio(bus_mio), .bus_wr(bus_wr), .bus_dc(bus_dc), .bus_addr(bus_addr),
        .bus_dout(bus_dout), .bus_oe(bus_oe), .bus_din(bus_din), .bus_rdy(bus_rdy),
        .instr_out(instr_out), .instr_vld(instr_vld), .rdat_out(rdat_out),
        .rdat_vld(rdat_vld)
    );

    // Behavioural reference: 0 fetching, 1 waiting for request, 2 executing
    int          m_st;
    logic [31:0] m_ip, m_a, m_w, m_iq, m_rq;
    logic [2:0]  m_k;
    logic        m_iv, m_rv;
    logic        m_first, m_spur, m_skip, m_jmp, m_hold;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_ip = 0; m_a = 0; m_w = 0; m_iq = 0; m_rq = 0; m_k = 0;
            m_iv = 0; m_rv = 0;
            m_first = 1; m_spur = 0; m_skip = 0; m_jmp = 0; m_hold = 0;
        end else begin
            m_first = 0;
            m_iv = 0; m_rv = 0; m_skip = 0; m_jmp = 0;
            m_spur = req_valid && (m_st != 1);
            m_hold = (m_st != 1) && !bus_rdy;
            if (m_st == 0) begin
                if (bus_rdy) begin
                    m_iq = bus_din; m_iv = 1; m_ip = m_ip + 4; m_st = 1;
                end
            end else if (m_st == 1) begin
                if (req_valid) begin
                    if (req_jump) begin m_ip = req_target; m_jmp = 1; end
                    m_k = req_kind; m_a = req_addr; m_w = req_wdata;
                    if (req_kind >= 3'd1 && req_kind <= 3'd4) m_st = 2;
                    else begin m_st = 0; m_skip = 1; end
                end
            end else begin
                if (bus_rdy) begin
                    if (m_k == 3'd1 || m_k == 3'd3) begin m_rq = bus_din; m_rv = 1; end
                    m_st = 0;
                end
            end
        end
    end

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic string main_tag();
        if (m_first)     return "R1";
        if (m_spur)      return "R10";
        if (m_skip)      return "R6";
        if (m_jmp)       return "R4";
        if (m_hold)      return "R7";
        if (m_st == 0)   return "R2";
        if (m_st == 2)   return "R5";
        return "R9";
    endfunction

    task automatic compare_all();
        string t;
        logic  e_cyc, e_mio, e_wr, e_dc, e_oe;
        logic [31:0] e_addr;
        t     = main_tag();
        e_cyc = (m_st != 1);
        e_dc  = (m_st == 2);
        e_mio = (m_st == 0) || (m_st == 2 && (m_k == 3'd1 || m_k == 3'd2));
        e_wr  = (m_st == 2) && (m_k == 3'd2 || m_k == 3'd4);
        e_oe  = e_wr;
        e_addr = (m_st == 0) ? m_ip : (m_st == 2) ? m_a : 32'h0;
        chk(t, "cyc", 32'(bus_cyc), 32'(e_cyc));
        chk(t, "strobes mio/wr/dc", {29'h0, bus_mio, bus_wr, bus_dc}, {29'h0, e_mio, e_wr, e_dc});
        chk((m_st == 0 && !m_jmp && !m_first) ? "R3" : t, "addr", bus_addr, e_addr);
        chk("R9", "oe", 32'(bus_oe), 32'(e_oe));
        chk("R9", "dout", bus_dout, e_oe ? m_w : 32'h0);
        chk("R10", "req_ready", 32'(req_ready), 32'(m_st == 1));
        chk(m_first ? "R1" : "R2", "instr_vld", 32'(instr_vld), 32'(m_iv));
        chk("R2", "instr_out", instr_out, m_iq);
        chk(m_first ? "R1" : "R8", "rdat_vld", 32'(rdat_vld), 32'(m_rv));
        chk("R8", "rdat_out", rdat_out, m_rq);
    endtask

    logic [15:0] lfsr = 16'hACE1;
    int idx = 0;
    int cyc_cnt = 0;
    bit wd_hit = 0;

    initial begin
        req_valid = 0; req_kind = 0; req_addr = 0; req_wdata = 0;
        req_jump = 0; req_target = 0; bus_rdy = 0; bus_din = 0;
        repeat (3) @(negedge clk);
        compare_all(); // R1 state during reset
        rst_n = 1'b1;
        while (idx < N_REQ + 1 && !wd_hit) begin
            @(negedge clk);
            cyc_cnt++;
            if (cyc_cnt > WD_LIMIT) begin
                wd_hit = 1;
                n_tests++; n_fail++;
                $display("FAIL watchdog: actual %0d cycles expected <= %0d", cyc_cnt, WD_LIMIT);
            end else begin
                compare_all();
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                if (bus_cyc) begin
                    bus_rdy = lfsr[0] | lfsr[1];
                    bus_din = {bus_addr[15:0], lfsr};
                end else begin
                    bus_rdy = 0; bus_din = 0;
                end
                if (req_ready) begin
                    if (lfsr[2] | lfsr[3]) begin
                        req_valid  = 1;
                        req_kind   = 3'(idx % 8);
                        req_addr   = 32'h2000_0000 + 32'(idx * 8);
                        req_wdata  = 32'hC0DE_0000 + 32'(idx);
                        req_jump   = (idx % 5 == 2);
                        req_target = 32'h0001_0000 + 32'(idx * 256);
                        idx++;
                    end else begin
                        req_valid = 0;
                    end
                end else begin
                    // R10: spurious request while busy must be ignored
                    req_valid  = lfsr[4];
                    req_kind   = 3'd2;
                    req_addr   = 32'hFFFF_0000;
                    req_wdata  = 32'h0;
                    req_jump   = 1;
                    req_target = 32'hDEAD_BEE0;
                end
            end
        end
        repeat (8) begin
            @(negedge clk);
            if (!wd_hit) compare_all();
            req_valid = 0; bus_rdy = bus_cyc;
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule